// File: doc/BRIEF.md
# Four-Lane Gather and Bit-Scatter Unit

This unit moves data between one packed 32-bit word and four separate 32-bit element lanes. It is aimed at pixel work. Gather folds four lanes into a single word, either by adding them or by multiplying them. When the four inputs hold fields in disjoint bit positions, the add form is the same as a bitwise OR, so it packs an RGBA pixel. Scatter does the reverse. It takes lane 0 as a packed source and a field width from 1 to 8 bits. It returns four lanes, each holding one field shifted down to bit 0 with everything above the field cleared.

Requests enter on a valid/ready stream and results leave on a valid/ready stream. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Only one operation is in flight at a time, so `in_ready` stays low from acceptance until the result has been taken. Add and scatter produce their result one cycle after acceptance. Multiply performs three sequential multiplies before its result appears. The result is taken on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the result is held unchanged.

Top module: `qg_unit`

## Requirements
- R1: Op code 0 (gather-add) returns out_sum = lane0 + lane1 + lane2 + lane3 modulo 2^32, with out_lanes all zero.
- R2: When the four input lanes hold fields in disjoint bit ranges, the gather-add result equals the bitwise OR of the four lanes.
- R3: Op code 1 (gather-multiply) returns out_sum = lane0 × lane1 × lane2 × lane3 modulo 2^32, formed by three sequential multiplies, with out_lanes all zero.
- R4: Op code 2 (scatter) with field width b returns output lane i (bits 32i+31..32i of out_lanes) = (lane0 >> (i×b)) AND (2^b − 1) for i = 0..3, with out_sum zero.
- R5: Scatter with b = 8 returns the four bytes of lane0 with the least significant byte first, each in bits 7..0 of its output lane.
- R6: In every scatter output lane, all bits at or above position b are zero.
- R7: A field width of 0 or above 8 is treated as 8.
- R8: Op code 3 behaves exactly as gather-add.
- R9: From acceptance until the result is taken, in_ready is low. A request presented in that time is ignored and produces no result.
- R10: While out_valid is high and out_ready is low, out_valid, out_sum and out_lanes hold their values.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 2 | 0 add, 1 multiply, 2 scatter, 3 add |
| in_elems | input | 128 | Four 32-bit lanes; lane i in bits 32i+31..32i; lane 0 is the scatter source |
| in_bits | input | 4 | Scatter field width |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 32 | Gather result |
| out_lanes | output | 128 | Scatter lanes; lane i in bits 32i+31..32i |

## Verification
Two things can meet in one cycle. A request can be presented while a multiply is still working. Separately, a result can be stalled by a low out_ready at the moment the next request is waiting. The bench provokes the first by presenting a scatter request right after a multiply is accepted. It judges that case from the low in_ready and from the scoreboard, which must see only the multiply result and no extra output. It provokes the second with an out_ready pattern that drops one cycle in three. The held outputs are compared from one sampled cycle to the next, and every result is checked in order against the expected queue.

// File: rtl/qg_pkg.sv
package qg_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_MUL  = 2'd1,
    OP_SCAT = 2'd2,
    OP_ADD2 = 2'd3
  } qg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_OUT  = 2'd2
  } qg_state_e;
endpackage

// File: rtl/qg_add_tree.sv
module qg_add_tree #(
  parameter int W     = 32,
  parameter int LANES = 4
) (
  input  logic [LANES*W-1:0] elems,
  output logic [W-1:0]       sum
);
  always_comb begin
    sum = '0;
    for (int k = 0; k < LANES; k++) sum = sum + elems[k*W +: W];
  end
endmodule

// File: rtl/qg_scatter.sv
module qg_scatter #(
  parameter int W     = 32,
  parameter int LANES = 4,
  parameter int BW    = 4
) (
  input  logic [W-1:0]       src,
  input  logic [BW-1:0]      width,
  output logic [LANES*W-1:0] lanes
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] mask;
  assign mask = (W'(1) << width) - W'(1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SHW-1:0] sh;
    assign sh = SHW'(i) * SHW'(width);
    assign lanes[i*W +: W] = (src >> sh) & mask;
  end
endmodule

// File: rtl/qg_mul_seq.sv
module qg_mul_seq #(
  parameter int W     = 32,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LANES*W-1:0] elems,
  output logic               busy,
  output logic               done,
  output logic [W-1:0]       prod
);
  localparam int CW = (LANES > 2) ? $clog2(LANES) : 1;

  logic [W-1:0]  acc;
  logic [W-1:0]  opnd [1:LANES-1];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      acc  <= '0;
      cnt  <= '0;
      for (int k = 1; k < LANES; k++) opnd[k] <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        acc  <= elems[W-1:0];
        for (int k = 1; k < LANES; k++) opnd[k] <= elems[k*W +: W];
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        acc <= acc * opnd[cnt + CW'(1)];
        cnt <= cnt + CW'(1);
        if (cnt == CW'(LANES - 2)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign prod = acc;
endmodule

// File: rtl/qg_unit.sv
module qg_unit
  import qg_pkg::*;
#(
  parameter int W     = 32,
  parameter int LANES = 4,
  parameter int MAXB  = 8,
  parameter int BW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_op,
  input  logic [LANES*W-1:0] in_elems,
  input  logic [BW-1:0]      in_bits,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [W-1:0]       out_sum,
  output logic [LANES*W-1:0] out_lanes
);
  qg_state_e         state;
  logic              accept, mul_start, mul_busy, mul_done;
  logic [W-1:0]      add_sum, mul_prod, sum_q;
  logic [LANES*W-1:0] scat_lanes, lanes_q;
  logic [BW-1:0]     eff_bits;
  qg_op_e            op;

  assign op        = qg_op_e'(in_op);
  assign accept    = in_valid && in_ready;
  assign mul_start = accept && (op == OP_MUL);
  assign eff_bits  = (in_bits == '0 || in_bits > BW'(MAXB)) ? BW'(MAXB) : in_bits;

  qg_add_tree #(.W(W), .LANES(LANES)) u_add (
    .elems (in_elems),
    .sum   (add_sum)
  );

  qg_scatter #(.W(W), .LANES(LANES), .BW(BW)) u_scat (
    .src   (in_elems[W-1:0]),
    .width (eff_bits),
    .lanes (scat_lanes)
  );

  qg_mul_seq #(.W(W), .LANES(LANES)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mul_start),
    .elems (in_elems),
    .busy  (mul_busy),
    .done  (mul_done),
    .prod  (mul_prod)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sum_q   <= '0;
      lanes_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          if (op == OP_MUL) begin
            state <= ST_MUL;
          end else begin
            state   <= ST_OUT;
            sum_q   <= (op == OP_SCAT) ? '0 : add_sum;
            lanes_q <= (op == OP_SCAT) ? scat_lanes : '0;
          end
        end
        ST_MUL: if (mul_done && !mul_busy) begin
          state   <= ST_OUT;
          sum_q   <= mul_prod;
          lanes_q <= '0;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_OUT);
  assign out_sum   = sum_q;
  assign out_lanes = lanes_q;
endmodule

// File: rtl/qg_unit_chk.sv
module qg_unit_chk #(
  parameter int W     = 32,
  parameter int LANES = 4,
  parameter int MAXB  = 8,
  parameter int BW    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [1:0]         in_op,
  input logic [LANES*W-1:0] in_elems,
  input logic [BW-1:0]      in_bits,
  input logic               out_valid,
  input logic               out_ready,
  input logic [W-1:0]       out_sum,
  input logic [LANES*W-1:0] out_lanes
);
  logic [W-1:0] ref_sum;
  always_comb begin
    ref_sum = '0;
    for (int k = 0; k < LANES; k++) ref_sum = ref_sum + in_elems[k*W +: W];
  end

  logic acc_add, acc_scat, acc_any, narrow;
  assign acc_any  = in_valid && in_ready;
  assign acc_add  = acc_any && (in_op == 2'd0 || in_op == 2'd3);
  assign acc_scat = acc_any && (in_op == 2'd2);
  assign narrow   = (in_bits != '0) && (in_bits <= BW'(MAXB));

  // R10: a stalled result holds still
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_lanes)));

  // R9: nothing is accepted once an operation is in flight
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_any |=> !in_ready);

  // R9: a pending result blocks new requests
  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R1 and R8: add result one cycle after acceptance
  p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_add |=> (out_valid && out_sum == $past(ref_sum) && out_lanes == '0));

  // R4: scatter leaves out_sum zero
  p_scat_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_scat |=> (out_valid && out_sum == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_hi
    // R6: bits above the field width are clear in each lane
    p_hi_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_scat && narrow) |=> ((out_lanes[i*W +: W] >> $past(in_bits)) == '0));
  end
endmodule

bind qg_unit qg_unit_chk #(.W(W), .LANES(LANES), .MAXB(MAXB), .BW(BW)) u_chk (.*);

// File: tb/qg_unit_tb.sv
module qg_unit_tb;
  localparam int W = 32;
  localparam int LANES = 4;
  localparam int BW = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [1:0]         in_op = 2'd0;
  logic [LANES*W-1:0] in_elems = '0;
  logic [BW-1:0]      in_bits = '0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic [W-1:0]       out_sum;
  logic [LANES*W-1:0] out_lanes;

  always #2 clk = ~clk;

  qg_unit u_dut (.*);

  int total = 0;
  int bad = 0;
  int pushed = 0;
  int popped = 0;
  bit finished = 1'b0;

  logic [W-1:0]       q_sum [$];
  logic [LANES*W-1:0] q_lanes [$];
  string              q_tag [$];

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [LANES*W-1:0] ref_scatter(input logic [W-1:0] src, input logic [BW-1:0] b);
    logic [LANES*W-1:0] r;
    int eb;
    eb = (b == 0 || b > 8) ? 8 : int'(b);
    for (int i = 0; i < LANES; i++)
      r[i*W +: W] = (src >> (i*eb)) & ((32'd1 << eb) - 32'd1);
    return r;
  endfunction

  task automatic send(input logic [1:0] op, input logic [LANES*W-1:0] e,
                      input logic [BW-1:0] b, input string tag);
    logic [W-1:0] s;
    s = '0;
    if (op == 2'd1) begin
      s = 32'd1;
      for (int k = 0; k < LANES; k++) s = s * e[k*W +: W];
      q_sum.push_back(s); q_lanes.push_back('0);
    end else if (op == 2'd2) begin
      q_sum.push_back('0); q_lanes.push_back(ref_scatter(e[W-1:0], b));
    end else begin
      for (int k = 0; k < LANES; k++) s = s + e[k*W +: W];
      q_sum.push_back(s); q_lanes.push_back('0);
    end
    q_tag.push_back(tag);
    pushed++;
    in_op = op; in_elems = e; in_bits = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: drives out_ready, pops and compares results
  int cyc = 0;
  logic               held_v = 1'b0;
  logic [W-1:0]       held_s;
  logic [LANES*W-1:0] held_l;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (held_v)
          check(out_valid && out_sum == held_s && out_lanes == held_l, "R10 hold",
                {out_sum, out_lanes[95:0]}, {held_s, held_l[95:0]});
        out_ready = (cyc % 3 != 1);
        held_v = out_valid && !out_ready;
        held_s = out_sum; held_l = out_lanes;
        if (out_valid && out_ready) begin
          popped++;
          if (q_sum.size() == 0) begin
            check(1'b0, "R9 unexpected result", {out_sum, out_lanes[95:0]}, '0);
          end else begin
            logic [W-1:0] es;
            logic [LANES*W-1:0] el;
            string t;
            es = q_sum.pop_front(); el = q_lanes.pop_front(); t = q_tag.pop_front();
            check(out_sum == es, {t, " sum"}, out_sum, es);
            check(out_lanes == el, {t, " lanes"}, out_lanes, el);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R11 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 after release", {out_valid, in_ready}, 2'b01);

    // R1: gather-add, including wrap
    send(2'd0, {32'd4, 32'd3, 32'd2, 32'd1}, 4'd0, "R1 small");
    send(2'd0, {32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'd5}, 4'd0, "R1 wrap");
    // R2: disjoint fields pack like OR
    send(2'd0, {32'h1200_0000, 32'h00EF_0000, 32'h0000_CD00, 32'h0000_00AB}, 4'd0, "R2 pixel");
    check((32'h1200_0000 | 32'h00EF_0000 | 32'h0000_CD00 | 32'h0000_00AB) == 32'h12EF_CDAB,
          "R2 or-model", 32'h12EF_CDAB, 32'h12EF_CDAB);
    // R8: op 3 acts as add
    send(2'd3, {32'd100, 32'd200, 32'd300, 32'd400}, 4'd0, "R8 alias");
    // R3: multiply, small and wrapping
    send(2'd1, {32'd5, 32'd4, 32'd3, 32'd2}, 4'd0, "R3 small");
    send(2'd1, {32'h0001_0001, 32'h0000_FFFF, 32'h1234_5678, 32'h9ABC_DEF1}, 4'd0, "R3 wrap");
    // R9: request presented while the multiply is working
    send(2'd1, {32'd7, 32'd11, 32'd13, 32'd17}, 4'd0, "R3 busy");
    in_op = 2'd2; in_elems = {96'd0, 32'hDEAD_BEEF}; in_bits = 4'd8; in_valid = 1'b1;
    check(in_ready == 1'b0, "R9 ready low 1", in_ready, 0);
    @(negedge clk);
    check(in_ready == 1'b0, "R9 ready low 2", in_ready, 0);
    in_valid = 1'b0;
    // R5: byte scatter
    send(2'd2, {96'd0, 32'hA1B2_C3D4}, 4'd8, "R5 bytes");
    // R4 and R6: narrow fields, with junk in the other lanes
    send(2'd2, {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF}, 4'd5, "R6 five");
    send(2'd2, {96'd0, 32'h0000_0B6D}, 4'd3, "R4 three");
    send(2'd2, {96'd0, 32'h0000_000A}, 4'd1, "R4 one");
    // R7: out-of-range widths
    send(2'd2, {96'd0, 32'h0102_0304}, 4'd0, "R7 zero");
    send(2'd2, {96'd0, 32'h5566_7788}, 4'd12, "R7 twelve");
    send(2'd0, {32'd1, 32'd1, 32'd1, 32'd1}, 4'd0, "R1 last");

    while (q_sum.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    check(popped == pushed, "R9 result count", popped, pushed);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule